// File: doc/BRIEF.md
# Descriptor Chain Walker

This block is the read-side front end of a DMA engine. In list mode it walks a chain of descriptors held in memory. Each descriptor is a four-word record, and the block reads it one word at a time through a 32-bit memory read port. Each descriptor names a buffer, and for a buffer of nonzero length the block presents one burst request. It then moves on to the next descriptor until it reaches one flagged as the terminator. In direct mode it skips the chain and issues a single burst, taken from a base register and a size register. The block does not move data itself. A downstream mover consumes its burst requests.

Software uses a small write/read register port. It programs the base and size registers, then writes a mode word with the start bit and the source list-enable bit. It then waits for the completion status bit, or for the interrupt line gated by the enable register. Status bits are cleared by writing ones. Six fault inputs from the surrounding datapath are collected into the same status word. A free-running cycle counter with its own enable is provided for measuring delays.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset, no fetch request and no burst request are driven, the interrupt line is low, and the mode, status and interrupt-enable registers read as zero.
- R2: A descriptor at address D is read as four words at D, D+4, D+8 and D+12, in that order. The words are, in order: buffer address, buffer length in bytes, next-descriptor address, flags. Only one read is outstanding at a time, and the request and its address stay unchanged until `mrd_ack`.
- R3: A descriptor with nonzero length produces exactly one burst, carrying its buffer address and length. The burst stays unchanged until `burst_ready`.
- R4: After a descriptor that is not a terminator, the next fetch starts at that descriptor's next-descriptor address.
- R5: A descriptor with flags bit 31 set ends the walk once its burst, if any, is accepted, and its next pointer is ignored. At that point status bit 0 sets and mode bit 31 (active) reads 0.
- R6: A descriptor of zero length produces no burst and raises no error, and the walk continues.
- R7: A non-terminating descriptor with a next pointer of zero stops the walk, sets status bit 8 (descriptor error) and leaves status bit 0 clear.
- R8: A fetch answered with `mrd_err` stops the walk after that word, sets status bit 8, and produces no burst.
- R9: When started with mode bit 25 (source list enable) clear and a nonzero size register, the block issues one burst with the base register as address and the size register as length, then sets status bit 0.
- R10: When started with mode bit 25 clear and a size register of zero, the block sets status bit 0 with no fetch and no burst.
- R11: Register map by `reg_addr`: 0 mode, 1 size, 2 base, 3 status, 4 interrupt enable, 5 counter control (bit 0), 6 counter value, 7 reads zero. Writing 1 to a status bit clears it and writing 0 leaves it. `fault_in[k]` sets status bit k+2. `irq` is high whenever an enabled status bit is set.
- R12: A write to the mode register while the walk is active is ignored.
- R13: The counter value increments by one on every clock while counter control bit 0 is set, and any write to the counter value register clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mrd_req | output | 1 | Descriptor word read request |
| mrd_addr | output | 32 | Descriptor word byte address |
| mrd_ack | input | 1 | Read response valid, completes the request |
| mrd_err | input | 1 | Read response carries an error |
| mrd_data | input | 32 | Read response word |
| burst_valid | output | 1 | Burst request valid |
| burst_addr | output | 32 | Burst buffer address |
| burst_len | output | 32 | Burst length in bytes |
| burst_ready | input | 1 | Burst request accepted |
| fault_in | input | 6 | Datapath fault pulses for status bits 2 to 7 |
| irq | output | 1 | Interrupt request |

## Verification
The hold checks on the fetch and burst requests assume two things. The memory side keeps `mrd_ack` low until it has a response, and it never acknowledges without a request. The burst side only raises `burst_ready` against a valid request. The stimulus models both sides as responders that react only to a raised request: the memory answers after a fixed two-cycle delay, and the burst side accepts after one cycle. The clear-on-write check and the check that active falls only with completion or error assume that the status register is not cleared in the same cycle as a set. The bench writes status only while the block is idle.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
    localparam int WORD_W  = 32;
    localparam int STAT_W  = 9;
    localparam int FAULT_W = 6;
    localparam int RSEL_W  = 3;

    localparam logic [RSEL_W-1:0] RA_MODE = 3'd0;
    localparam logic [RSEL_W-1:0] RA_SIZE = 3'd1;
    localparam logic [RSEL_W-1:0] RA_BASE = 3'd2;
    localparam logic [RSEL_W-1:0] RA_STAT = 3'd3;
    localparam logic [RSEL_W-1:0] RA_IEN  = 3'd4;
    localparam logic [RSEL_W-1:0] RA_PCTL = 3'd5;
    localparam logic [RSEL_W-1:0] RA_PCNT = 3'd6;

    localparam int MB_ACTIVE = 31;
    localparam int MB_SRC_LL = 25;
    localparam int MB_DST_LL = 24;
    localparam int FLAG_LAST = 31;
    localparam int SB_DONE   = 0;
    localparam int SB_FAULT0 = 2;
    localparam int SB_DESC   = 8;

    typedef enum logic [1:0] {W_IDLE, W_FETCH, W_EVAL, W_ISSUE} wstate_e;
endpackage

// File: rtl/dcw_perf.sv
module dcw_perf #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_bit,
    input  logic             cnt_we,
    output logic             en_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } perf_t;

    perf_t q, d;

    always_comb begin
        d = q;
        if (ctl_we) d.en = ctl_bit;
        if (cnt_we)     d.cnt = '0;
        else if (q.en)  d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_o  = q.en;
    assign cnt_o = q.cnt;

    // R13
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && !cnt_we) |=> (q.cnt == $past(q.cnt) + 1'b1));
endmodule

// File: rtl/dcw_regs.sv
module dcw_regs
    import dcw_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RSEL_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              derr_i,
    input  logic [FAULT_W-1:0] fault_i,
    input  logic              perf_en_i,
    input  logic [CNT_W-1:0]  perf_cnt_i,
    output logic              start_o,
    output logic              start_list_o,
    output logic [WORD_W-1:0] size_o,
    output logic [WORD_W-1:0] base_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              src_ll;
        logic              dst_ll;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] base;
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] ien;
    } regs_t;

    regs_t q, d;
    logic              mode_wr;
    logic [STAT_W-1:0] set_v, clr_v;

    always_comb begin
        d       = q;
        mode_wr = we && (addr == RA_MODE) && !busy_i;
        set_v   = '0;
        set_v[SB_DONE] = done_i;
        set_v[SB_DESC] = derr_i;
        set_v[SB_FAULT0 +: FAULT_W] = fault_i;
        clr_v   = (we && addr == RA_STAT) ? wdata[STAT_W-1:0] : '0;
        if (mode_wr) begin
            d.src_ll = wdata[MB_SRC_LL];
            d.dst_ll = wdata[MB_DST_LL];
        end
        if (we && addr == RA_SIZE) d.size = wdata;
        if (we && addr == RA_BASE) d.base = wdata;
        if (we && addr == RA_IEN)  d.ien  = wdata[STAT_W-1:0];
        d.stat = (q.stat & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_MODE: begin
                rdata[MB_ACTIVE] = busy_i;
                rdata[MB_SRC_LL] = q.src_ll;
                rdata[MB_DST_LL] = q.dst_ll;
            end
            RA_SIZE: rdata = q.size;
            RA_BASE: rdata = q.base;
            RA_STAT: rdata[STAT_W-1:0] = q.stat;
            RA_IEN:  rdata[STAT_W-1:0] = q.ien;
            RA_PCTL: rdata[0] = perf_en_i;
            RA_PCNT: rdata[CNT_W-1:0] = perf_cnt_i;
            default: rdata = '0;
        endcase
    end

    assign start_o      = mode_wr && wdata[MB_ACTIVE];
    assign start_list_o = wdata[MB_SRC_LL];
    assign size_o       = q.size;
    assign base_o       = q.base;
    assign irq_o        = |(q.stat & q.ien);

    // R11
    w1c_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_STAT && wdata[SB_DONE] && !done_i) |=> !q.stat[SB_DONE]);
    // R5
    end_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |-> (q.stat[SB_DONE] || q.stat[SB_DESC]));
endmodule

// File: rtl/dcw_walker.sv
module dcw_walker
    import dcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              list_i,
    input  logic [WORD_W-1:0] size_i,
    input  logic [WORD_W-1:0] base_i,
    output logic              mrd_req,
    output logic [WORD_W-1:0] mrd_addr,
    input  logic              mrd_ack,
    input  logic              mrd_err,
    input  logic [WORD_W-1:0] mrd_data,
    output logic              burst_valid,
    output logic [WORD_W-1:0] burst_addr,
    output logic [WORD_W-1:0] burst_len,
    input  logic              burst_ready,
    output logic              busy_o,
    output logic              done_o,
    output logic              derr_o
);
    localparam int NWORDS = 4;
    localparam int IDX_W  = $clog2(NWORDS);

    typedef struct packed {
        wstate_e           st;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] baddr;
        logic [WORD_W-1:0] blen;
        logic [WORD_W-1:0] nxt;
        logic              last;
        logic              direct;
    } walk_t;

    walk_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        derr_o = 1'b0;
        case (q.st)
            W_IDLE: if (start_i) begin
                if (list_i) begin
                    d.st = W_FETCH; d.idx = '0; d.cur = base_i; d.direct = 1'b0;
                end else if (size_i == '0) begin
                    done_o = 1'b1;
                end else begin
                    d.st = W_ISSUE; d.baddr = base_i; d.blen = size_i; d.direct = 1'b1;
                end
            end
            W_FETCH: if (mrd_ack) begin
                if (mrd_err) begin
                    derr_o = 1'b1;
                    d.st   = W_IDLE;
                end else begin
                    case (q.idx)
                        2'd0:    d.baddr = mrd_data;
                        2'd1:    d.blen  = mrd_data;
                        2'd2:    d.nxt   = mrd_data;
                        default: d.last  = mrd_data[FLAG_LAST];
                    endcase
                    if (q.idx == IDX_W'(NWORDS-1)) d.st = W_EVAL;
                    else                           d.idx = q.idx + 1'b1;
                end
            end
            W_EVAL: begin
                if (q.blen != '0) begin
                    d.st = W_ISSUE;
                end else if (q.last) begin
                    done_o = 1'b1; d.st = W_IDLE;
                end else if (q.nxt == '0) begin
                    derr_o = 1'b1; d.st = W_IDLE;
                end else begin
                    d.cur = q.nxt; d.idx = '0; d.st = W_FETCH;
                end
            end
            W_ISSUE: if (burst_ready) begin
                if (q.direct) begin
                    done_o = 1'b1; d.st = W_IDLE;
                end else begin
                    d.blen = '0; d.st = W_EVAL;
                end
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = (q.st != W_IDLE);
    assign mrd_req     = (q.st == W_FETCH);
    assign mrd_addr    = q.cur + {{(WORD_W-IDX_W-2){1'b0}}, q.idx, 2'b00};
    assign burst_valid = (q.st == W_ISSUE);
    assign burst_addr  = q.baddr;
    assign burst_len   = q.blen;

    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_addr)));
    // R3
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_addr) && $stable(burst_len)));
    // R6
    burst_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_len != '0));
    // R8
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && mrd_ack && mrd_err) |=> (!mrd_req && !burst_valid));
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
    import dcw_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                mrd_req,
    output logic [31:0]         mrd_addr,
    input  logic                mrd_ack,
    input  logic                mrd_err,
    input  logic [31:0]         mrd_data,
    output logic                burst_valid,
    output logic [31:0]         burst_addr,
    output logic [31:0]         burst_len,
    input  logic                burst_ready,
    input  logic [5:0]          fault_in,
    output logic                irq
);
    logic              start, start_list, busy, done, derr, perf_en;
    logic [WORD_W-1:0] size_r, base_r;
    logic [CNT_W-1:0]  perf_cnt;

    dcw_regs #(.CNT_W(CNT_W)) u_regs (
        .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .busy_i(busy), .done_i(done), .derr_i(derr), .fault_i(fault_in),
        .perf_en_i(perf_en), .perf_cnt_i(perf_cnt),
        .start_o(start), .start_list_o(start_list), .size_o(size_r), .base_o(base_r),
        .irq_o(irq)
    );

    dcw_walker u_walk (
        .clk, .rst_n, .start_i(start), .list_i(start_list), .size_i(size_r), .base_i(base_r),
        .mrd_req, .mrd_addr, .mrd_ack, .mrd_err, .mrd_data,
        .burst_valid, .burst_addr, .burst_len, .burst_ready,
        .busy_o(busy), .done_o(done), .derr_o(derr)
    );

    dcw_perf #(.CNT_W(CNT_W)) u_perf (
        .clk, .rst_n,
        .ctl_we(reg_we && reg_addr == RA_PCTL), .ctl_bit(reg_wdata[0]),
        .cnt_we(reg_we && reg_addr == RA_PCNT),
        .en_o(perf_en), .cnt_o(perf_cnt)
    );
endmodule

// File: tb/desc_chain_walker_bench.sv
module desc_chain_walker_bench;
    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        mrd_req, mrd_ack = 0, mrd_err = 0;
    logic [31:0] mrd_addr, mrd_data = 0;
    logic        burst_valid, burst_ready = 0;
    logic [31:0] burst_addr, burst_len;
    logic [5:0]  fault_in = 0;
    logic        irq;

    desc_chain_walker u_desc_chain_walker (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [0:255];
    logic [31:0] err_addr = 32'hFFFF_FFFC;
    logic [31:0] exp_fetch[$];
    logic [31:0] exp_ba[$];
    logic [31:0] exp_bl[$];
    int lat = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: answers two cycles after a request is seen
    always @(posedge clk) begin
        if (mrd_ack) begin
            mrd_ack <= 0; mrd_err <= 0; lat <= 0;
        end else if (mrd_req) begin
            if (lat == 1) begin
                mrd_ack  <= 1;
                mrd_data <= mem[mrd_addr[9:2]];
                mrd_err  <= (mrd_addr == err_addr);
            end else lat <= lat + 1;
        end
    end

    // burst acceptor: one cycle after valid
    always @(posedge clk) burst_ready <= burst_valid && !burst_ready;

    // per-clock reference comparison of the request streams
    always @(negedge clk) if (rst_n) begin
        if (mrd_req) begin
            if (exp_fetch.size() == 0) chk(0, "R2 unexpected fetch", mrd_addr, 0);
            else if (mrd_addr != exp_fetch[0]) chk(0, "R2/R4 fetch address", mrd_addr, exp_fetch[0]);
            else if (mrd_ack) begin chk(1, "R2", mrd_addr, exp_fetch[0]); void'(exp_fetch.pop_front()); end
        end
        if (burst_valid && burst_ready) begin
            if (exp_ba.size() == 0) chk(0, "R3/R6 unexpected burst", burst_addr, 0);
            else begin
                chk(burst_addr == exp_ba[0], "R3 burst addr", burst_addr, exp_ba[0]);
                chk(burst_len == exp_bl[0], "R3 burst len", burst_len, exp_bl[0]);
                void'(exp_ba.pop_front()); void'(exp_bl.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic put_desc(input int at, input logic [31:0] ba, bl, nx, fl);
        mem[at/4] = ba; mem[at/4+1] = bl; mem[at/4+2] = nx; mem[at/4+3] = fl;
    endtask

    task automatic expect_fetch(input logic [31:0] at, input int n);
        for (int i = 0; i < n; i++) exp_fetch.push_back(at + 32'(4*i));
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk); rd(0, v);
            if (!v[31]) break;
        end
    endtask

    task automatic queues_empty(input string tag);
        chk(exp_fetch.size() == 0, tag, 32'(exp_fetch.size()), 0);
        chk(exp_ba.size() == 0, tag, 32'(exp_ba.size()), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mrd_req && !burst_valid, "R1 requests", {mrd_req, burst_valid}, 0);
        chk(!irq, "R1 irq", irq, 0);
        rd(0, v); chk(v == 0, "R1 mode", v, 0);
        rst_n = 1;
        @(negedge clk);
        rd(3, v); chk(v == 0, "R1 status", v, 0);
        rd(4, v); chk(v == 0, "R1 enable", v, 0);

        // R2 R3 R4 R5 R6 R12: three-descriptor chain, middle one empty, last has stray next
        put_desc(32'h100, 32'h1000, 64, 32'h140, 0);
        put_desc(32'h140, 32'h2000, 0,  32'h180, 0);
        put_desc(32'h180, 32'h3000, 20, 32'h1F0, 32'h8000_0000);
        expect_fetch(32'h100, 4); expect_fetch(32'h140, 4); expect_fetch(32'h180, 4);
        exp_ba.push_back(32'h1000); exp_bl.push_back(64);
        exp_ba.push_back(32'h3000); exp_bl.push_back(20);
        wr(4, 32'h001);
        wr(1, 0);
        wr(2, 32'h100);
        wr(0, 32'h8200_0000);
        repeat (4) @(negedge clk);
        wr(0, 32'h0000_0000);          // R12 ignored while active
        wait_idle();
        queues_empty("R4/R5/R6 chain fully walked");
        rd(3, v); chk(v == 32'h001, "R5/R6 status done only", v, 32'h001);
        rd(0, v); chk(v == 32'h0200_0000, "R12/R5 mode kept, active clear", v, 32'h0200_0000);
        chk(irq == 1, "R11 irq on enabled done", irq, 1);

        // R11 clear on write-one
        wr(3, 32'h000); rd(3, v); chk(v == 32'h001, "R11 write zero keeps", v, 32'h001);
        wr(3, 32'h001); rd(3, v); chk(v == 0, "R11 write one clears", v, 0);
        chk(irq == 0, "R11 irq low after clear", irq, 0);

        // R7 zero next pointer without terminator
        put_desc(32'h200, 32'h4000, 8, 0, 0);
        expect_fetch(32'h200, 4);
        exp_ba.push_back(32'h4000); exp_bl.push_back(8);
        wr(2, 32'h200); wr(0, 32'h8200_0000);
        wait_idle();
        queues_empty("R7 walk");
        rd(3, v); chk(v == 32'h100, "R7 descriptor error", v, 32'h100);
        wr(3, 32'h1FF);

        // R8 fetch error on second word
        put_desc(32'h240, 32'h6000, 16, 32'h280, 0);
        err_addr = 32'h244;
        expect_fetch(32'h240, 2);
        wr(2, 32'h240); wr(0, 32'h8200_0000);
        wait_idle();
        queues_empty("R8 stop after error");
        rd(3, v); chk(v == 32'h100, "R8 error status", v, 32'h100);
        err_addr = 32'hFFFF_FFFC;
        wr(3, 32'h1FF);

        // R9 direct transfer
        exp_ba.push_back(32'h5000); exp_bl.push_back(100);
        wr(1, 100); wr(2, 32'h5000); wr(0, 32'h8000_0000);
        wait_idle();
        queues_empty("R9 single burst");
        rd(3, v); chk(v == 32'h001, "R9 done", v, 32'h001);
        wr(3, 32'h1FF);

        // R10 direct with zero size
        wr(1, 0); wr(0, 32'h8000_0000);
        rd(0, v); chk(v[31] == 0, "R10 never active", v, 0);
        rd(3, v); chk(v == 32'h001, "R10 done without data", v, 32'h001);
        repeat (5) @(negedge clk);
        queues_empty("R10 no fetch or burst");
        wr(3, 32'h1FF);

        // R11 fault input mapping and gating
        wr(4, 32'h000);
        fault_in = 6'b000010; @(negedge clk); fault_in = 0;
        rd(3, v); chk(v == 32'h008, "R11 fault bit 3", v, 32'h008);
        chk(irq == 0, "R11 masked fault", irq, 0);
        wr(4, 32'h008);
        chk(irq == 1, "R11 enabled fault", irq, 1);
        wr(3, 32'h008); wr(4, 0);

        // R13 cycle counter
        wr(6, 0);
        wr(5, 1);
        repeat (10) @(negedge clk);
        wr(5, 0);
        rd(6, v); chk(v == 11, "R13 count while enabled", v, 11);
        repeat (3) @(negedge clk);
        rd(6, v); chk(v == 11, "R13 holds when disabled", v, 11);
        wr(6, 32'h55);
        rd(6, v); chk(v == 0, "R13 write clears", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule